// File: doc/BRIEF.md
# Performance-Unit Selector Register with Privilege Gate

This block keeps a small selector register that chooses one system performance-monitor unit and one bank of sixteen event counters inside that unit. Every read or write request to the selector first goes through a privilege gate. The gate looks at the current exception level, the feature flags and the enable and trap controls that each higher level owns. In the same cycle it returns one outcome: the access completes, the access is undefined, or the access traps to level 1, 2 or 3.

The outcome is combinational. The selector changes on a clock edge only when a write request resolves as completed. The current unit, the bank, the first counter index of the bank and a flag for reserved unit codes are always present at the outputs, so the counter logic elsewhere can decode them directly.

Top module: `pmu_sel_gate`

## Requirements
- R1: After reset, `unitSel`, `bankSel` and `baseCounter` are all 0 and `reservedSel` is 0.
- R2: Only two fields are writable: bits 9:4 hold the unit and bits 1:0 hold the bank. Bits 63:10 and 3:2 read as zero and writes to them have no effect.
- R3: `baseCounter` equals the bank code times 16. Bank 0 gives 0, bank 1 gives 16, bank 2 gives 32 and bank 3 gives 48.
- R4: `reservedSel` is 1 exactly when the stored unit code lies in 0x20..0x3F.
- R5: When `featUnit` or `featWide` is 0, the result is 1 (undefined) at every level. Result codes: 0 ok, 1 undefined, 2 trap to level 1, 3 trap to level 2, 4 trap to level 3.
- R6: At levels 0 to 2, if `el3Present`, `undefFirst` and a zero `lvl3Enable` all hold, the result is 1. This check takes precedence over every trap.
- R7: At level 0 only, the next check is `lvl1Enable`. If it is 0, the result is 3 when both `el2Enabled` and `trapGenEx` are 1, and 2 otherwise.
- R8: The next check is the fine-grained trap. It always applies at level 1, and at level 0 it applies only when `hostMode` is 0. It gives result 3 when `el2Enabled` and `featFine` are both 1 and either (`el3Present` and `lvl3FineEn`=0) or the active-low bit for the direction is 0. Reads use `fineReadN` and writes use `fineWriteN`.
- R9: At levels 0 and 1, the next check gives result 3 when `el2Enabled` is 1 and `lvl2Enable` is 0.
- R10: The last check at levels 0 to 2 applies when `el3Present` is 1 and `lvl3Enable` is 0. It gives result 1 if `secDebugUndef` is 1, and result 4 otherwise.
- R11: Level 2 applies only the checks of R6 and R10. Level 3 always gives result 0 once the features are present.
- R12: `syndClass` is 0x18 for results 2 to 4 and 0 for any other result. `rdData` is zero unless the result is 0.
- R13: The selector is written only on a clock edge where `reqValid` and `reqWrite` are both 1 and the result is 0. An undefined write, a trapped write or a write without `reqValid` leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| wrData | input | 64 | Write data |
| curLevel | input | 2 | Current exception level, 0 to 3 |
| featUnit | input | 1 | Performance-unit feature present |
| featWide | input | 1 | 64-bit state feature present |
| featFine | input | 1 | Fine-grained trap feature present |
| el2Enabled | input | 1 | Level 2 is enabled |
| el3Present | input | 1 | Level 3 exists |
| undefFirst | input | 1 | Undefined outcome takes priority |
| secDebugUndef | input | 1 | A level-3 denial is undefined rather than a trap |
| hostMode | input | 1 | Level 0 runs under a host at level 2 |
| trapGenEx | input | 1 | Level-0 traps are routed to level 2 |
| lvl1Enable | input | 1 | Level-1 enable for level-0 access |
| lvl2Enable | input | 1 | Level-2 enable |
| lvl3Enable | input | 1 | Level-3 enable |
| lvl3FineEn | input | 1 | Level-3 enable for fine-grained traps |
| fineReadN | input | 1 | Active-low fine-grained read permit |
| fineWriteN | input | 1 | Active-low fine-grained write permit |
| rdData | output | 64 | Selector image when the result is ok, zero otherwise |
| result | output | 3 | Outcome code (see R5) |
| syndClass | output | 6 | Syndrome class, 0x18 on a trap |
| unitSel | output | 6 | Stored unit code |
| bankSel | output | 2 | Stored bank code |
| baseCounter | output | 6 | First counter index of the bank |
| reservedSel | output | 1 | Stored unit code is reserved |

## Verification
The hardest cases to reach are the ones where two checks both want to fire, so that only the priority order decides the result. Examples are an undefined-first denial together with a missing level-2 enable, a level-0 request that host mode exempts from a fine-grained denial that would otherwise trap, and a write that is denied only by the write-side fine-grained bit. The vector table reaches each of these by starting from an all-permitting control set and clearing only the controls that the case needs. The directed writes then read the selector back at level 3 after each denied write, to show that it did not change.

// File: rtl/pmuSelPkg.sv
package pmuSelPkg;
  localparam int REG_W         = 64;
  localparam int UNIT_W        = 6;
  localparam int UNIT_LSB      = 4;
  localparam int BANK_W        = 2;
  localparam int CTRS_PER_BANK = 16;
  localparam int SYND_W        = 6;
  localparam logic [SYND_W-1:0] SYND_CLASS = 6'h18;

  typedef enum logic [2:0] {
    RES_OK    = 3'd0,
    RES_UNDEF = 3'd1,
    RES_TRAP1 = 3'd2,
    RES_TRAP2 = 3'd3,
    RES_TRAP3 = 3'd4
  } accRes_e;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } dpStrobe_t;
endpackage

// File: rtl/pmuSelCtrl.sv
module pmuSelCtrl
  import pmuSelPkg::*;
#(
  parameter int SW = SYND_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [1:0]    curLevel,
  input  logic          featUnit,
  input  logic          featWide,
  input  logic          featFine,
  input  logic          el2Enabled,
  input  logic          el3Present,
  input  logic          undefFirst,
  input  logic          secDebugUndef,
  input  logic          hostMode,
  input  logic          trapGenEx,
  input  logic          lvl1Enable,
  input  logic          lvl2Enable,
  input  logic          lvl3Enable,
  input  logic          lvl3FineEn,
  input  logic          fineReadN,
  input  logic          fineWriteN,
  output accRes_e       result,
  output logic [SW-1:0] syndClass,
  output dpStrobe_t     strobe
);
  logic featOk;
  logic undefEarly;
  logic lvl3Deny;
  logic finePermitN;
  logic fineHit;
  logic fineApplies;

  assign featOk      = featUnit & featWide;
  assign undefEarly  = el3Present & undefFirst & ~lvl3Enable;
  assign lvl3Deny    = el3Present & ~lvl3Enable;
  assign finePermitN = reqWrite ? fineWriteN : fineReadN;
  assign fineHit     = el2Enabled & featFine &
                       ((el3Present & ~lvl3FineEn) | ~finePermitN);
  assign fineApplies = (curLevel == 2'd1) | ((curLevel == 2'd0) & ~hostMode);

  always_comb begin
    result = RES_OK;
    if (!featOk) begin
      result = RES_UNDEF;
    end else if (curLevel != 2'd3) begin
      if (undefEarly) begin
        result = RES_UNDEF;
      end else if (curLevel == 2'd0 && !lvl1Enable) begin
        result = (el2Enabled && trapGenEx) ? RES_TRAP2 : RES_TRAP1;
      end else if (fineApplies && fineHit) begin
        result = RES_TRAP2;
      end else if (curLevel != 2'd2 && el2Enabled && !lvl2Enable) begin
        result = RES_TRAP2;
      end else if (lvl3Deny) begin
        result = secDebugUndef ? RES_UNDEF : RES_TRAP3;
      end
    end
  end

  always_comb begin
    syndClass = '0;
    if (result == RES_TRAP1 || result == RES_TRAP2 || result == RES_TRAP3)
      syndClass = SW'(SYND_CLASS);
  end

  assign strobe.rdEn = (result == RES_OK);
  assign strobe.wrEn = reqValid & reqWrite & (result == RES_OK);

  // R5
  feat_missing_undef_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!featUnit || !featWide) |-> result == RES_UNDEF);
  // R11
  top_level_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (featUnit && featWide && curLevel == 2'd3) |-> result == RES_OK);
  // R11
  lvl2_no_low_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curLevel == 2'd2) |-> (result != RES_TRAP1 && result != RES_TRAP2));
  // R12
  synd_on_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syndClass != '0) |-> (result != RES_OK && result != RES_UNDEF));
endmodule

// File: rtl/pmuSelDp.sv
module pmuSelDp
  import pmuSelPkg::*;
#(
  parameter int RW  = REG_W,
  parameter int UW  = UNIT_W,
  parameter int ULSB = UNIT_LSB,
  parameter int BW  = BANK_W,
  parameter int CPB = CTRS_PER_BANK,
  localparam int CTR_SH = $clog2(CPB),
  localparam int BASE_W = BW + CTR_SH
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [RW-1:0]     wrData,
  output logic [RW-1:0]     rdData,
  output logic [UW-1:0]     unitSel,
  output logic [BW-1:0]     bankSel,
  output logic [BASE_W-1:0] baseCounter,
  output logic              reservedSel
);
  localparam logic [UW-1:0] RSV_FROM = UW'(1) << (UW - 1);

  logic [UW-1:0] unitQ;
  logic [BW-1:0] bankQ;
  logic [RW-1:0] image;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitQ <= '0;
      bankQ <= '0;
    end else if (strobe.wrEn) begin
      unitQ <= wrData[ULSB +: UW];
      bankQ <= wrData[BW-1:0];
    end
  end

  always_comb begin
    image = '0;
    image[ULSB +: UW] = unitQ;
    image[BW-1:0]     = bankQ;
  end

  assign rdData      = strobe.rdEn ? image : '0;
  assign unitSel     = unitQ;
  assign bankSel     = bankQ;
  assign baseCounter = {bankQ, {CTR_SH{1'b0}}};
  assign reservedSel = (unitQ >= RSV_FROM);

  // R13
  hold_on_deny_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> ($stable(unitQ) && $stable(bankQ)));
  // R2
  gap_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[ULSB-1:BW] == '0) && (rdData[RW-1:ULSB+UW] == '0));
endmodule

// File: rtl/pmu_sel_gate.sv
module pmu_sel_gate
  import pmuSelPkg::*;
#(
  parameter int RW  = REG_W,
  parameter int UW  = UNIT_W,
  parameter int ULSB = UNIT_LSB,
  parameter int BW  = BANK_W,
  parameter int CPB = CTRS_PER_BANK,
  parameter int SW  = SYND_W,
  localparam int BASE_W = BW + $clog2(CPB)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [RW-1:0]     wrData,
  input  logic [1:0]        curLevel,
  input  logic              featUnit,
  input  logic              featWide,
  input  logic              featFine,
  input  logic              el2Enabled,
  input  logic              el3Present,
  input  logic              undefFirst,
  input  logic              secDebugUndef,
  input  logic              hostMode,
  input  logic              trapGenEx,
  input  logic              lvl1Enable,
  input  logic              lvl2Enable,
  input  logic              lvl3Enable,
  input  logic              lvl3FineEn,
  input  logic              fineReadN,
  input  logic              fineWriteN,
  output logic [RW-1:0]     rdData,
  output logic [2:0]        result,
  output logic [SW-1:0]     syndClass,
  output logic [UW-1:0]     unitSel,
  output logic [BW-1:0]     bankSel,
  output logic [BASE_W-1:0] baseCounter,
  output logic              reservedSel
);
  dpStrobe_t strobe;
  accRes_e   resCode;

  pmuSelCtrl #(.SW(SW)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .curLevel(curLevel), .featUnit(featUnit), .featWide(featWide),
    .featFine(featFine), .el2Enabled(el2Enabled), .el3Present(el3Present),
    .undefFirst(undefFirst), .secDebugUndef(secDebugUndef),
    .hostMode(hostMode), .trapGenEx(trapGenEx), .lvl1Enable(lvl1Enable),
    .lvl2Enable(lvl2Enable), .lvl3Enable(lvl3Enable),
    .lvl3FineEn(lvl3FineEn), .fineReadN(fineReadN), .fineWriteN(fineWriteN),
    .result(resCode), .syndClass(syndClass), .strobe(strobe)
  );

  pmuSelDp #(.RW(RW), .UW(UW), .ULSB(ULSB), .BW(BW), .CPB(CPB)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdData(rdData), .unitSel(unitSel), .bankSel(bankSel),
    .baseCounter(baseCounter), .reservedSel(reservedSel)
  );

  assign result = resCode;
endmodule

// File: tb/pmu_sel_gate_tb.sv
module pmu_sel_gate_tb;
  typedef struct packed {
    logic [1:0] lvl;
    logic wr, fu, fw, ff, e2, e3p, up, sdu, host, tge;
    logic en1, en2, en3, fen3, frn, fwn;
    logic [2:0] exp;
  } vec_t;

  // Field order: lvl wr fu fw ff e2 e3p up sdu host tge en1 en2 en3 fen3 frn fwn exp
  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{2'd3,0,1,1,1,1,1,1,0,0,0,0,0,0,0,0,0,3'd0}, // R11 level 3 always ok
    '{2'd3,0,0,1,1,1,1,0,0,0,0,1,1,1,1,1,1,3'd1}, // R5
    '{2'd0,1,1,0,1,1,1,0,0,0,0,1,1,1,1,1,1,3'd1}, // R5
    '{2'd1,0,1,1,1,1,1,1,0,0,0,1,0,0,1,1,1,3'd1}, // R6 beats level-2 trap
    '{2'd0,0,1,1,1,1,1,1,0,0,0,0,1,0,1,1,1,3'd1}, // R6 beats level-1 enable
    '{2'd0,0,1,1,1,1,1,0,0,0,1,0,1,1,1,1,1,3'd3}, // R7 routed to level 2
    '{2'd0,0,1,1,1,0,1,0,0,0,1,0,1,1,1,1,1,3'd2}, // R7 level 2 disabled
    '{2'd0,0,1,1,1,1,1,0,0,0,0,0,1,1,1,1,1,3'd2}, // R7 no route
    '{2'd1,0,1,1,1,1,1,0,0,0,0,1,1,1,1,0,1,3'd3}, // R8 read bit
    '{2'd1,1,1,1,1,1,1,0,0,0,0,1,1,1,1,0,1,3'd0}, // R8 write ignores read bit
    '{2'd1,1,1,1,1,1,1,0,0,0,0,1,1,1,1,1,0,3'd3}, // R8 write bit
    '{2'd1,0,1,1,1,1,1,0,0,0,0,1,1,1,1,1,0,3'd0}, // R8 read ignores write bit
    '{2'd0,0,1,1,1,1,1,0,0,1,0,1,1,1,1,0,1,3'd0}, // R8 host exempts level 0
    '{2'd0,0,1,1,1,1,1,0,0,0,0,1,1,1,1,0,1,3'd3}, // R8 level 0 no host
    '{2'd1,0,1,1,1,1,1,0,0,1,0,1,1,1,1,0,1,3'd3}, // R8 host irrelevant level 1
    '{2'd1,0,1,1,1,1,1,0,0,0,0,1,1,1,0,1,1,3'd3}, // R8 level-3 fine enable
    '{2'd1,0,1,1,1,1,0,0,0,0,0,1,1,1,0,1,1,3'd0}, // R8 no level 3
    '{2'd1,0,1,1,0,1,1,0,0,0,0,1,1,1,1,0,1,3'd0}, // R8 feature absent
    '{2'd1,0,1,1,1,0,1,0,0,0,0,1,1,1,1,0,1,3'd0}, // R8 level 2 disabled
    '{2'd1,0,1,1,1,1,1,0,0,0,0,1,0,1,1,1,1,3'd3}, // R9
    '{2'd1,0,1,1,1,0,1,0,0,0,0,1,0,1,1,1,1,3'd0}, // R9 level 2 disabled
    '{2'd1,0,1,1,1,1,1,0,0,0,0,1,1,0,1,1,1,3'd4}, // R10 trap
    '{2'd0,0,1,1,1,1,1,0,1,0,0,1,1,0,1,1,1,3'd1}, // R10 undef
    '{2'd0,0,1,1,1,1,0,0,0,0,0,1,1,0,1,1,1,3'd0}, // R10 no level 3
    '{2'd2,0,1,1,1,1,1,0,0,0,0,0,0,1,1,0,0,3'd0}, // R11 level 2 skips lower checks
    '{2'd2,0,1,1,1,1,1,1,0,0,0,1,1,0,1,1,1,3'd1}  // R11 level 2 with R6
  };

  logic clk = 0;
  logic rstN = 0;
  logic reqValid = 0, reqWrite = 0;
  logic [63:0] wrData = '0;
  logic [1:0] curLevel = 2'd3;
  logic featUnit = 1, featWide = 1, featFine = 1, el2Enabled = 1, el3Present = 1;
  logic undefFirst = 0, secDebugUndef = 0, hostMode = 0, trapGenEx = 0;
  logic lvl1Enable = 1, lvl2Enable = 1, lvl3Enable = 1, lvl3FineEn = 1;
  logic fineReadN = 1, fineWriteN = 1;
  logic [63:0] rdData;
  logic [2:0] result;
  logic [5:0] syndClass, unitSel, baseCounter;
  logic [1:0] bankSel;
  logic reservedSel;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pmu_sel_gate u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .wrData(wrData), .curLevel(curLevel), .featUnit(featUnit),
    .featWide(featWide), .featFine(featFine), .el2Enabled(el2Enabled),
    .el3Present(el3Present), .undefFirst(undefFirst),
    .secDebugUndef(secDebugUndef), .hostMode(hostMode),
    .trapGenEx(trapGenEx), .lvl1Enable(lvl1Enable), .lvl2Enable(lvl2Enable),
    .lvl3Enable(lvl3Enable), .lvl3FineEn(lvl3FineEn), .fineReadN(fineReadN),
    .fineWriteN(fineWriteN), .rdData(rdData), .result(result),
    .syndClass(syndClass), .unitSel(unitSel), .bankSel(bankSel),
    .baseCounter(baseCounter), .reservedSel(reservedSel)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic permitAll();
    featUnit = 1; featWide = 1; featFine = 1; el2Enabled = 1; el3Present = 1;
    undefFirst = 0; secDebugUndef = 0; hostMode = 0; trapGenEx = 0;
    lvl1Enable = 1; lvl2Enable = 1; lvl3Enable = 1; lvl3FineEn = 1;
    fineReadN = 1; fineWriteN = 1;
  endtask

  // read the stored selector at level 3 and compare every view of it
  task automatic readBack(input string req, input logic [5:0] u, input logic [1:0] b);
    @(negedge clk);
    permitAll(); curLevel = 2'd3; reqValid = 1; reqWrite = 0;
    #2;
    check(req, rdData, {54'd0, u, 2'b00, b});
    check(req, {58'd0, unitSel}, {58'd0, u});
    check(req, {62'd0, bankSel}, {62'd0, b});
    check("R3", {58'd0, baseCounter}, {58'd0, b, 4'b0000});
    check("R4", {63'd0, reservedSel}, {63'd0, u >= 6'h20});
    reqValid = 0;
  endtask

  task automatic writeSel(input logic [1:0] lvl, input logic [63:0] d, input logic v);
    @(negedge clk);
    curLevel = lvl; reqWrite = 1; reqValid = v; wrData = d;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0; reqWrite = 0; wrData = '0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values seen while reset is held
    check("R1", {58'd0, unitSel}, 64'd0);
    check("R1", {62'd0, bankSel}, 64'd0);
    check("R1", {58'd0, baseCounter}, 64'd0);
    check("R1", {63'd0, reservedSel}, 64'd0);
    rstN = 1;
    readBack("R1", 6'h00, 2'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      curLevel = VEC[i].lvl; reqWrite = VEC[i].wr; reqValid = 0;
      featUnit = VEC[i].fu; featWide = VEC[i].fw; featFine = VEC[i].ff;
      el2Enabled = VEC[i].e2; el3Present = VEC[i].e3p; undefFirst = VEC[i].up;
      secDebugUndef = VEC[i].sdu; hostMode = VEC[i].host; trapGenEx = VEC[i].tge;
      lvl1Enable = VEC[i].en1; lvl2Enable = VEC[i].en2; lvl3Enable = VEC[i].en3;
      lvl3FineEn = VEC[i].fen3; fineReadN = VEC[i].frn; fineWriteN = VEC[i].fwn;
      #2;
      check($sformatf("R5-R11 vec%0d", i), {61'd0, result}, {61'd0, VEC[i].exp});
      check("R12 synd", {58'd0, syndClass},
            (VEC[i].exp >= 3'd2) ? 64'h18 : 64'h0);
      if (VEC[i].exp != 3'd0) check("R12 rdData", rdData, 64'd0);
    end
    reqWrite = 0;

    // R2 R3 R4 writes at level 3
    permitAll();
    writeSel(2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    readBack("R2 all ones", 6'h3F, 2'd3);
    writeSel(2'd3, 64'hA5A5_0000_0000_0155, 1);
    readBack("R2 gap bits", 6'h15, 2'd1);
    writeSel(2'd3, 64'h0000_0000_0000_0200, 1);
    readBack("R4 first reserved", 6'h20, 2'd0);
    writeSel(2'd3, 64'h0000_0000_0000_01F2, 1);
    readBack("R4 last normal", 6'h1F, 2'd2);

    // R13 trapped write at level 1 (level-2 enable cleared)
    permitAll(); lvl2Enable = 0;
    writeSel(2'd1, 64'h3FF, 1);
    readBack("R13 trapped", 6'h1F, 2'd2);
    // R13 undefined write (feature absent)
    permitAll(); featWide = 0;
    writeSel(2'd0, 64'h3FF, 1);
    readBack("R13 undefined", 6'h1F, 2'd2);
    // R13 write without reqValid
    permitAll();
    writeSel(2'd3, 64'h3FF, 0);
    readBack("R13 no valid", 6'h1F, 2'd2);
    // R13 ok write at level 0
    permitAll();
    writeSel(2'd0, 64'h0C3, 1);
    readBack("R13 ok level0", 6'h0C, 2'd3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule